// File: doc/BRIEF.md
# Register-List Replay Engine

The engine replays lists of register writes that software has placed in memory. Each list entry is 8 bytes. The word at the lower address is the data value and the word 4 bytes above it is the target register offset. Software sets up three regions and then sets the run bit:

- a double-buffered region, with its own base address and count;
- a single-buffered region, which holds a high-priority part followed directly by a low-priority part.

The engine then fetches entries one word at a time over a request/acknowledge memory read port. For each entry it issues one write on a valid/ready register-write port.

When every non-empty region has been replayed, the engine clears its run bit on its own and raises one completion flag per region that it ran. A failed memory read stops the engine and raises a read-error flag. An error response on the write port stops the engine, raises a bus-error flag and captures the faulting offset. Each flag has its own interrupt enable, and a single interrupt line reports them.

The sequencer moves through these states:

- `ST_IDLE`: waits for the run bit. Takes the *start* transition to `ST_PICK`.
- `ST_PICK`: steps through the three region slots in the selected order.
  - *skip*: a region with a zero count is passed over and the engine stays in `ST_PICK`.
  - *load*: a non-empty region goes to `ST_FETCH_VAL`.
  - *exhausted*: after the third slot the engine goes to `ST_DONE`.
- `ST_FETCH_VAL`: fetches the value word. On an acknowledge it moves to `ST_FETCH_OFS`, or on a failed read it takes *read-abort* to `ST_IDLE`.
- `ST_FETCH_OFS`: fetches the offset word. On an acknowledge it moves to `ST_ISSUE`, or takes *read-abort*.
- `ST_ISSUE`: presents the register write. On a handshake:
  - *next-entry* goes back to `ST_FETCH_VAL`;
  - *region-end* goes back to `ST_PICK`;
  - an error response takes *bus-abort* to `ST_IDLE`.
- `ST_DONE`: posts the completion flags, clears the run bit and takes the *finish* transition to `ST_IDLE`.

Top module: `regwr_replay`

## Requirements
- R1: After reset every register reads zero, and `irq`, `mem_req` and `wr_valid` are low. The registers are:
  - `CTRL` at 0x00;
  - `DBBASE` at 0x10;
  - `DBCNT` at 0x14;
  - `SBBASE` at 0x18;
  - `SBCNT` at 0x1C;
  - `ERRADDR` at 0x20.
- R2: Each entry at address A produces exactly one register write. The write has `wr_data` equal to the memory word at A and `wr_addr` equal to the memory word at A+4. Entries within a region are replayed at ascending addresses, 8 bytes apart.
- R3: The replay order is set by `CTRL` bit 1, the order select.
  - With bit 1 at 0: high-priority single-buffered entries, then low-priority entries, then double-buffered entries.
  - With bit 1 at 1: double-buffered entries first, then high-priority, then low-priority.
  - Field positions: `SBCNT[15:0]` is the high-priority count and `SBCNT[31:16]` is the low-priority count. The double-buffered count is `DBCNT[15:0]`.
  - The low-priority entries start at `SBBASE + 8*high_count`.
- R4: A region with a zero count is skipped. With all three counts zero, the run bit clears within 8 cycles of the write that set it, and `mem_req` is never raised.
- R5: At the end of a replay the engine clears `CTRL` bit 0 (run). It sets a completion flag only for each region with a non-zero count:
  - `CTRL` bit 17 for double-buffered;
  - `CTRL` bit 18 for high-priority;
  - `CTRL` bit 19 for low-priority.

  While the run bit is clear, no memory read or register write is issued.
- R6: The status flags sit at `CTRL` bits 22:16:
  - 16: read error;
  - 17–19: completions (see R5);
  - 20 and 21: reserved, always zero;
  - 22: bus error.

  Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R7: `irq` is high exactly when some flag bit `CTRL[16+k]` and its enable `CTRL[2+k]` are both 1, for k = 0..6.
- R8: While the run bit is set, writes to `DBBASE`, `DBCNT`, `SBBASE`, `SBCNT` and to the order-select bit are ignored, and the replay in progress is unaffected.
- R9: A memory response with `mem_err` high sets flag bit 16 and clears the run bit. No further write is issued and no completion flag is set.
- R10: A write handshake with `wr_err` high sets flag bit 22, stores that write's `wr_addr` in `ERRADDR` and clears the run bit. No further request is issued and no completion flag is set.
- R11: The write port holds `wr_valid`, `wr_addr` and `wr_data` steady while `wr_ready` is low. The read port holds `mem_req` and `mem_addr` steady until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW | Register byte offset for reads and writes |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from `cfg_addr` |
| mem_req | output | 1 | Memory read request, held until acknowledged |
| mem_addr | output | ADDR_W | Memory word address |
| mem_ack | input | 1 | Memory response strobe |
| mem_rdata | input | 32 | Memory response data |
| mem_err | input | 1 | Memory response is a failed read |
| wr_valid | output | 1 | Register write valid |
| wr_ready | input | 1 | Register write accepted |
| wr_addr | output | 32 | Target register offset |
| wr_data | output | 32 | Register write value |
| wr_err | input | 1 | Error response, sampled with the handshake |
| irq | output | 1 | Interrupt: OR of enabled flags |

## Verification
The assertions check the following on every cycle:
- both ports hold steady under back-pressure;
- the engine is quiet whenever the run bit is clear;
- each completion or error flag appears together with the run bit clearing;
- the faulting offset is captured;
- the count registers stay frozen during a replay;
- `irq` stays low when no enabled flag is set.

Only the bench's scenarios can show the rest:
- the exact write sequence, meaning the value/offset pairing, the packed low-priority placement and both replay orders, swept over all counts from 0 to 2 per region;
- which completion flags are set;
- write-one-to-clear;
- that an abort truncates the list at the right entry.

// File: rtl/rr_pkg.sv
package rr_pkg;

    localparam int unsigned REG_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PICK,
        ST_FETCH_VAL,
        ST_FETCH_OFS,
        ST_ISSUE,
        ST_DONE
    } rr_state_e;

    // Region identifiers; completion flag of region k is flag bit 1+k.
    localparam int unsigned RG_DB  = 0;
    localparam int unsigned RG_SBH = 1;
    localparam int unsigned RG_SBL = 2;
    localparam int unsigned NUM_RG = 3;

    // Control word layout
    localparam int unsigned CTRL_RUN  = 0;
    localparam int unsigned CTRL_ORD  = 1;
    localparam int unsigned IE_LSB    = 2;
    localparam int unsigned FLAG_LSB  = 16;
    localparam int unsigned NFLAG     = 7;

    // Flag indices (relative to FLAG_LSB / IE_LSB)
    localparam int unsigned FL_RDERR  = 0;
    localparam int unsigned FL_COMP0  = 1;
    localparam int unsigned FL_BUSERR = 6;

    // Register byte offsets
    localparam int unsigned OFS_CTRL   = 'h00;
    localparam int unsigned OFS_DBBASE = 'h10;
    localparam int unsigned OFS_DBCNT  = 'h14;
    localparam int unsigned OFS_SBBASE = 'h18;
    localparam int unsigned OFS_SBCNT  = 'h1C;
    localparam int unsigned OFS_ERR    = 'h20;

    localparam int unsigned ENTRY_BYTES = 8;
    localparam int unsigned WORD_BYTES  = 4;

endpackage

// File: rtl/rr_regs.sv
module rr_regs
    import rr_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned CFG_AW = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CFG_AW-1:0]    cfg_addr,
    input  logic [REG_W-1:0]     cfg_wdata,
    output logic [REG_W-1:0]     cfg_rdata,
    input  logic                 fin,
    input  logic [NFLAG-1:0]     set_flags,
    input  logic                 err_we,
    input  logic [REG_W-1:0]     err_in,
    output logic                 run,
    output logic                 ord,
    output logic [ADDR_W-1:0]    db_base,
    output logic [CNT_W-1:0]     db_cnt,
    output logic [ADDR_W-1:0]    sb_base,
    output logic [CNT_W-1:0]     hp_cnt,
    output logic [CNT_W-1:0]     lp_cnt,
    output logic [NFLAG-1:0]     flags,
    output logic [NFLAG-1:0]     ie,
    output logic [REG_W-1:0]     err_addr,
    output logic                 irq
);

    logic hit_ctrl, hit_dbb, hit_dbc, hit_sbb, hit_sbc;
    logic [NFLAG-1:0] w1c;

    always_comb begin
        hit_ctrl = cfg_we && (cfg_addr == CFG_AW'(OFS_CTRL));
        hit_dbb  = cfg_we && (cfg_addr == CFG_AW'(OFS_DBBASE));
        hit_dbc  = cfg_we && (cfg_addr == CFG_AW'(OFS_DBCNT));
        hit_sbb  = cfg_we && (cfg_addr == CFG_AW'(OFS_SBBASE));
        hit_sbc  = cfg_we && (cfg_addr == CFG_AW'(OFS_SBCNT));
        w1c      = hit_ctrl ? cfg_wdata[FLAG_LSB +: NFLAG] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run      <= 1'b0;
            ord      <= 1'b0;
            ie       <= '0;
            flags    <= '0;
            db_base  <= '0;
            db_cnt   <= '0;
            sb_base  <= '0;
            hp_cnt   <= '0;
            lp_cnt   <= '0;
            err_addr <= '0;
        end else begin
            if (fin)
                run <= 1'b0;
            else if (hit_ctrl && cfg_wdata[CTRL_RUN])
                run <= 1'b1;
            if (hit_ctrl)
                ie <= cfg_wdata[IE_LSB +: NFLAG];
            if (hit_ctrl && !run)
                ord <= cfg_wdata[CTRL_ORD];
            flags <= (flags & ~w1c) | set_flags;
            if (!run) begin
                if (hit_dbb) db_base <= cfg_wdata[ADDR_W-1:0];
                if (hit_dbc) db_cnt  <= cfg_wdata[CNT_W-1:0];
                if (hit_sbb) sb_base <= cfg_wdata[ADDR_W-1:0];
                if (hit_sbc) begin
                    hp_cnt <= cfg_wdata[CNT_W-1:0];
                    lp_cnt <= cfg_wdata[16 +: CNT_W];
                end
            end
            if (err_we)
                err_addr <= err_in;
        end
    end

    assign irq = |(flags & ie);

    always_comb begin
        cfg_rdata = '0;
        unique case (cfg_addr)
            CFG_AW'(OFS_CTRL): begin
                cfg_rdata[CTRL_RUN]           = run;
                cfg_rdata[CTRL_ORD]           = ord;
                cfg_rdata[IE_LSB +: NFLAG]    = ie;
                cfg_rdata[FLAG_LSB +: NFLAG]  = flags;
            end
            CFG_AW'(OFS_DBBASE): cfg_rdata = REG_W'(db_base);
            CFG_AW'(OFS_DBCNT):  cfg_rdata = REG_W'(db_cnt);
            CFG_AW'(OFS_SBBASE): cfg_rdata = REG_W'(sb_base);
            CFG_AW'(OFS_SBCNT): begin
                cfg_rdata[CNT_W-1:0]   = hp_cnt;
                cfg_rdata[16 +: CNT_W] = lp_cnt;
            end
            CFG_AW'(OFS_ERR):    cfg_rdata = err_addr;
            default:             cfg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/rr_region_map.sv
module rr_region_map
    import rr_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 16
) (
    input  logic [ADDR_W-1:0] db_base,
    input  logic [CNT_W-1:0]  db_cnt,
    input  logic [ADDR_W-1:0] sb_base,
    input  logic [CNT_W-1:0]  hp_cnt,
    input  logic [CNT_W-1:0]  lp_cnt,
    input  logic              ord,
    input  logic [1:0]        slot,
    output logic              slot_ok,
    output logic [1:0]        rg_id,
    output logic [ADDR_W-1:0] rg_base,
    output logic [CNT_W-1:0]  rg_cnt
);

    localparam int unsigned SHIFT = $clog2(ENTRY_BYTES);

    logic [ADDR_W-1:0] base_tab [NUM_RG];
    logic [CNT_W-1:0]  cnt_tab  [NUM_RG];

    for (genvar g = 0; g < NUM_RG; g++) begin : g_rg
        if (g == RG_DB) begin : g_db
            assign base_tab[g] = db_base;
            assign cnt_tab[g]  = db_cnt;
        end else if (g == RG_SBH) begin : g_sbh
            assign base_tab[g] = sb_base;
            assign cnt_tab[g]  = hp_cnt;
        end else begin : g_sbl
            assign base_tab[g] = sb_base + (ADDR_W'(hp_cnt) << SHIFT);
            assign cnt_tab[g]  = lp_cnt;
        end
    end

    always_comb begin
        slot_ok = (slot < 2'(NUM_RG));
        if (ord)
            rg_id = slot;
        else
            rg_id = (slot == 2'd2) ? 2'(RG_DB) : slot + 2'd1;
        rg_base = '0;
        rg_cnt  = '0;
        if (slot_ok) begin
            unique case (rg_id)
                2'd0:    begin rg_base = base_tab[0]; rg_cnt = cnt_tab[0]; end
                2'd1:    begin rg_base = base_tab[1]; rg_cnt = cnt_tab[1]; end
                default: begin rg_base = base_tab[2]; rg_cnt = cnt_tab[2]; end
            endcase
        end
    end

endmodule

// File: rtl/rr_engine.sv
module rr_engine
    import rr_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              slot_ok,
    input  logic [1:0]        rg_id,
    input  logic [ADDR_W-1:0] rg_base,
    input  logic [CNT_W-1:0]  rg_cnt,
    output logic [1:0]        slot,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [REG_W-1:0]  mem_rdata,
    input  logic              mem_err,
    output logic              wr_valid,
    output logic [REG_W-1:0]  wr_addr,
    output logic [REG_W-1:0]  wr_data,
    input  logic              wr_ready,
    input  logic              wr_err,
    output logic              fin,
    output logic [NFLAG-1:0]  set_flags,
    output logic              err_we,
    output logic [REG_W-1:0]  err_addr
);

    rr_state_e          state, nxt;
    logic [CNT_W-1:0]   idx;
    logic [ADDR_W-1:0]  ptr;
    logic [REG_W-1:0]   val_q, ofs_q;
    logic [NUM_RG-1:0]  ran;
    logic               last;

    assign last = (idx + CNT_W'(1)) == rg_cnt;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      if (run) nxt = ST_PICK;
            ST_PICK: begin
                if (!slot_ok)          nxt = ST_DONE;
                else if (rg_cnt != '0) nxt = ST_FETCH_VAL;
            end
            ST_FETCH_VAL: if (mem_ack) nxt = mem_err ? ST_IDLE : ST_FETCH_OFS;
            ST_FETCH_OFS: if (mem_ack) nxt = mem_err ? ST_IDLE : ST_ISSUE;
            ST_ISSUE: begin
                if (wr_ready) begin
                    if (wr_err)    nxt = ST_IDLE;
                    else if (last) nxt = ST_PICK;
                    else           nxt = ST_FETCH_VAL;
                end
            end
            ST_DONE:      nxt = ST_IDLE;
            default:      nxt = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot  <= '0;
            idx   <= '0;
            ptr   <= '0;
            val_q <= '0;
            ofs_q <= '0;
            ran   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (run) begin
                        slot <= '0;
                        ran  <= '0;
                    end
                end
                ST_PICK: begin
                    if (slot_ok) begin
                        if (rg_cnt != '0) begin
                            ptr <= rg_base;
                            idx <= '0;
                        end else begin
                            slot <= slot + 2'd1;
                        end
                    end
                end
                ST_FETCH_VAL: begin
                    if (mem_ack && !mem_err) begin
                        val_q <= mem_rdata;
                        ptr   <= ptr + ADDR_W'(WORD_BYTES);
                    end
                end
                ST_FETCH_OFS: begin
                    if (mem_ack && !mem_err) begin
                        ofs_q <= mem_rdata;
                        ptr   <= ptr + ADDR_W'(WORD_BYTES);
                    end
                end
                ST_ISSUE: begin
                    if (wr_ready && !wr_err) begin
                        idx <= idx + CNT_W'(1);
                        if (last) begin
                            ran[rg_id] <= 1'b1;
                            slot       <= slot + 2'd1;
                        end
                    end
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_req   = 1'b0;
        wr_valid  = 1'b0;
        fin       = 1'b0;
        set_flags = '0;
        err_we    = 1'b0;
        unique case (state)
            ST_FETCH_VAL, ST_FETCH_OFS: begin
                mem_req = 1'b1;
                if (mem_ack && mem_err) begin
                    fin                 = 1'b1;
                    set_flags[FL_RDERR] = 1'b1;
                end
            end
            ST_ISSUE: begin
                wr_valid = 1'b1;
                if (wr_ready && wr_err) begin
                    fin                  = 1'b1;
                    set_flags[FL_BUSERR] = 1'b1;
                    err_we               = 1'b1;
                end
            end
            ST_DONE: begin
                fin = 1'b1;
                set_flags[FL_COMP0 +: NUM_RG] = ran;
            end
            default: ;
        endcase
    end

    assign mem_addr = ptr;
    assign wr_addr  = ofs_q;
    assign wr_data  = val_q;
    assign err_addr = ofs_q;

endmodule

// File: rtl/regwr_replay.sv
module regwr_replay
    import rr_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned CFG_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_err,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [31:0]       wr_addr,
    output logic [31:0]       wr_data,
    input  logic              wr_err,
    output logic              irq
);

    logic              run, ord, fin, err_we, slot_ok;
    logic [NFLAG-1:0]  set_flags, flags, ie;
    logic [REG_W-1:0]  err_in, err_addr;
    logic [ADDR_W-1:0] db_base, sb_base, rg_base;
    logic [CNT_W-1:0]  db_cnt, hp_cnt, lp_cnt, rg_cnt;
    logic [1:0]        slot, rg_id;

    rr_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .CFG_AW(CFG_AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .fin(fin),
        .set_flags(set_flags), .err_we(err_we), .err_in(err_in),
        .run(run), .ord(ord), .db_base(db_base), .db_cnt(db_cnt),
        .sb_base(sb_base), .hp_cnt(hp_cnt), .lp_cnt(lp_cnt),
        .flags(flags), .ie(ie), .err_addr(err_addr), .irq(irq)
    );

    rr_region_map #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_map (
        .db_base(db_base), .db_cnt(db_cnt), .sb_base(sb_base),
        .hp_cnt(hp_cnt), .lp_cnt(lp_cnt), .ord(ord), .slot(slot),
        .slot_ok(slot_ok), .rg_id(rg_id), .rg_base(rg_base), .rg_cnt(rg_cnt)
    );

    rr_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .run(run), .slot_ok(slot_ok),
        .rg_id(rg_id), .rg_base(rg_base), .rg_cnt(rg_cnt), .slot(slot),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .mem_err(mem_err), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
        .wr_err(wr_err), .fin(fin), .set_flags(set_flags),
        .err_we(err_we), .err_addr(err_in)
    );

endmodule

// File: rtl/rr_checks.sv
module rr_checks #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [31:0]       wr_addr,
    input logic [31:0]       wr_data,
    input logic [6:0]        flags,
    input logic [6:0]        ie,
    input logic              irq,
    input logic [31:0]       err_addr,
    input logic [CNT_W-1:0]  db_cnt,
    input logic [CNT_W-1:0]  hp_cnt,
    input logic [CNT_W-1:0]  lp_cnt
);

    // R11: write port holds its request under back-pressure
    assert_wr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    // R11: read request held until acknowledged
    assert_mem_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R5: no traffic while the run bit is clear
    assert_quiet_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!mem_req && !wr_valid));

    // R5: a newly set completion flag comes with the run bit cleared
    assert_comp_clears_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flags[3:1] & ~$past(flags[3:1]))) |-> !run);

    // R9: read error stops the engine
    assert_rderr_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[0]) |-> (!run && !mem_req && !wr_valid));

    // R10: bus error stops the engine and captures the faulting offset
    assert_buserr_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[6]) |-> (!run && err_addr == $past(wr_addr)));

    // R7: no enabled flag, no interrupt
    assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & ie) == 7'd0) |-> !irq);

    // R8: counts frozen during a replay
    assert_cnt_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> ($stable(db_cnt) && $stable(hp_cnt) && $stable(lp_cnt)));

endmodule

bind regwr_replay rr_checks #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_checks (
    .clk(clk), .rst_n(rst_n), .run(run), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .flags(flags), .ie(ie), .irq(irq), .err_addr(err_addr),
    .db_cnt(db_cnt), .hp_cnt(hp_cnt), .lp_cnt(lp_cnt)
);

// File: tb/regwr_replay_test.sv
`timescale 1ns/1ps
module regwr_replay_test;

    localparam int unsigned ADDR_W = 32;
    localparam int unsigned CFG_AW = 6;
    localparam logic [31:0] SB_BASE = 32'h0000_1000;
    localparam logic [31:0] DB_BASE = 32'h0000_8000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [CFG_AW-1:0] cfg_addr = '0;
    logic [31:0]       cfg_wdata = '0;
    logic [31:0]       cfg_rdata;
    logic              mem_req;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_ack = 1'b0;
    logic [31:0]       mem_rdata = '0;
    logic              mem_err = 1'b0;
    logic              wr_valid;
    logic              wr_ready = 1'b0;
    logic [31:0]       wr_addr, wr_data;
    logic              wr_err;
    logic              irq;

    int n_chk = 0;
    int n_bad = 0;

    // error injection
    logic        rd_inj = 1'b0;
    logic [31:0] rd_inj_addr = '0;
    logic        bus_inj = 1'b0;
    logic [31:0] bus_inj_ofs = '0;

    // logs
    logic [31:0] exp_a [0:15];
    logic [31:0] exp_d [0:15];
    logic [31:0] got_a [0:15];
    logic [31:0] got_d [0:15];
    int exp_n = 0;
    int got_n = 0;
    int req_cycles = 0;
    int rdy_cnt = 0;
    logic        stall_seen = 1'b0;
    logic [31:0] stall_a = '0, stall_d = '0;

    always #2.5 clk = ~clk;

    regwr_replay #(.ADDR_W(ADDR_W), .CFG_AW(CFG_AW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .mem_err(mem_err), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_err(wr_err), .irq(irq)
    );

    function automatic logic [31:0] word_at(logic [31:0] a);
        return (a * 32'h0001_0003) ^ 32'hC3A5_0000;
    endfunction

    assign wr_err = bus_inj && wr_valid && (wr_addr == bus_inj_ofs);

    // memory and write-port responders
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack  <= 1'b0;
            mem_err  <= 1'b0;
            wr_ready <= 1'b0;
            rdy_cnt  <= 0;
        end else begin
            mem_ack   <= mem_req && !mem_ack;
            mem_err   <= mem_req && !mem_ack && rd_inj && (mem_addr == rd_inj_addr);
            mem_rdata <= word_at(mem_addr);
            wr_ready  <= (rdy_cnt % 3) != 0;
            rdy_cnt   <= rdy_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req) req_cycles++;
            if (stall_seen) begin
                check(wr_valid && wr_addr == stall_a && wr_data == stall_d,
                      "R11 write held under back-pressure", wr_addr, stall_a);
            end
            stall_seen = wr_valid && !wr_ready;
            stall_a    = wr_addr;
            stall_d    = wr_data;
            if (wr_valid && wr_ready && got_n < 16) begin
                got_a[got_n] = wr_addr;
                got_d[got_n] = wr_data;
                got_n++;
            end
        end
    end

    task automatic cfg_write(input int ofs, input logic [31:0] d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = CFG_AW'(ofs);
        cfg_wdata = d;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic cfg_read(input int ofs, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = CFG_AW'(ofs);
        #1;
        d = cfg_rdata;
    endtask

    task automatic add_region(input logic [31:0] base, input int n);
        for (int i = 0; i < n; i++) begin
            exp_d[exp_n] = word_at(base + 32'(8 * i));
            exp_a[exp_n] = word_at(base + 32'(8 * i + 4));
            exp_n++;
        end
    endtask

    task automatic build_exp(input int hp, input int lp, input int db, input bit ord);
        exp_n = 0;
        if (ord) add_region(DB_BASE, db);
        add_region(SB_BASE, hp);
        add_region(SB_BASE + 32'(8 * hp), lp);
        if (!ord) add_region(DB_BASE, db);
    endtask

    task automatic start(input int hp, input int lp, input int db,
                         input bit ord, input logic [6:0] ie);
        got_n = 0;
        req_cycles = 0;
        cfg_write('h10, DB_BASE);
        cfg_write('h14, 32'(db));
        cfg_write('h18, SB_BASE);
        cfg_write('h1C, {16'(lp), 16'(hp)});
        cfg_write('h00, {23'd0, ie, ord, 1'b1});
    endtask

    task automatic wait_idle(input int limit, input string tag, output int took);
        logic [31:0] r;
        took = 0;
        r = 32'h1;
        while (r[0] && took < limit) begin
            cfg_read('h00, r);
            took++;
        end
        check(!r[0], {tag, " run bit self-clears"}, r, 32'h0);
    endtask

    task automatic compare_writes(input string tag);
        check(got_n == exp_n, {tag, " R3 write count"}, 32'(got_n), 32'(exp_n));
        for (int i = 0; i < exp_n && i < got_n; i++) begin
            check(got_d[i] == exp_d[i], {tag, " R2 write data"}, got_d[i], exp_d[i]);
            check(got_a[i] == exp_a[i], {tag, " R3 write offset/order"}, got_a[i], exp_a[i]);
        end
    endtask

    task automatic clear_flags();
        cfg_write('h00, 32'h007F_0000);
    endtask

    initial begin
        logic [31:0] r;
        logic [6:0]  ie, expf;
        int took;

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int k = 0; k < 6; k++) begin
            int ofs;
            ofs = (k == 0) ? 'h00 : ('h0C + 4 * k);
            cfg_read(ofs, r);
            check(r == 32'h0, "R1 register reset value", r, 32'h0);
        end
        check(!irq && !mem_req && !wr_valid, "R1 outputs idle after reset",
              {29'd0, irq, mem_req, wr_valid}, 32'h0);

        // R4: all counts zero
        start(0, 0, 0, 1'b0, 7'h0E);
        wait_idle(8, "R4 empty", took);
        check(req_cycles == 0, "R4 no memory reads when empty", 32'(req_cycles), 32'h0);
        cfg_read('h00, r);
        check(r[22:16] == 7'h0, "R4 no completion flags when empty", {25'd0, r[22:16]}, 32'h0);

        // Sweep: counts 0..2 per region, both orders
        for (int ord = 0; ord < 2; ord++) begin
            for (int hp = 0; hp < 3; hp++) begin
                for (int lp = 0; lp < 3; lp++) begin
                    for (int db = 0; db < 3; db++) begin
                        ie = ord ? 7'b000_1110 : 7'b000_0100;
                        build_exp(hp, lp, db, ord[0]);
                        start(hp, lp, db, ord[0], ie);
                        wait_idle(400, "R5 sweep", took);
                        compare_writes("sweep");
                        expf = {3'b000, lp != 0, hp != 0, db != 0, 1'b0};
                        cfg_read('h00, r);
                        check(r[22:16] == expf, "R5 completion flags",
                              {25'd0, r[22:16]}, {25'd0, expf});
                        check(irq == |(expf & ie), "R7 interrupt line",
                              {31'd0, irq}, {31'd0, |(expf & ie)});
                        clear_flags();
                        cfg_read('h00, r);
                        check(r[22:16] == 7'h0, "R6 write-one-to-clear",
                              {25'd0, r[22:16]}, 32'h0);
                        check(!irq, "R7 interrupt drops after clear", {31'd0, irq}, 32'h0);
                    end
                end
            end
        end

        // R6: writing zero leaves a flag set
        build_exp(1, 0, 0, 1'b0);
        start(1, 0, 0, 1'b0, 7'h00);
        wait_idle(400, "R6 setup", took);
        cfg_write('h00, 32'h0000_0000);
        cfg_read('h00, r);
        check(r[22:16] == 7'b000_0100, "R6 writing zero keeps flag",
              {25'd0, r[22:16]}, 32'h4);
        check(!irq, "R7 flag without enable gives no interrupt", {31'd0, irq}, 32'h0);
        clear_flags();

        // R8: configuration writes ignored while running
        build_exp(2, 1, 1, 1'b0);
        start(2, 1, 1, 1'b0, 7'h00);
        cfg_write('h14, 32'd5);
        cfg_write('h1C, 32'h0);
        cfg_write('h18, 32'h0000_4000);
        cfg_write('h00, 32'h0000_0003);
        cfg_read('h14, r);
        check(r == 32'd1, "R8 DB count locked", r, 32'd1);
        cfg_read('h1C, r);
        check(r == 32'h0001_0002, "R8 SB count locked", r, 32'h0001_0002);
        cfg_read('h18, r);
        check(r == SB_BASE, "R8 SB base locked", r, SB_BASE);
        wait_idle(400, "R8", took);
        compare_writes("R8 replay unaffected");
        cfg_read('h00, r);
        check(r[1] == 1'b0, "R8 order select locked", {31'd0, r[1]}, 32'h0);
        clear_flags();

        // R9: read error on the value word of high-priority entry 1
        rd_inj = 1'b1;
        rd_inj_addr = SB_BASE + 32'd8;
        build_exp(1, 0, 0, 1'b0);
        start(3, 0, 0, 1'b0, 7'h01);
        wait_idle(400, "R9", took);
        rd_inj = 1'b0;
        compare_writes("R9 truncated");
        cfg_read('h00, r);
        check(r[22:16] == 7'b000_0001, "R9 read-error flag only",
              {25'd0, r[22:16]}, 32'h1);
        check(irq, "R9 read-error interrupt", {31'd0, irq}, 32'h1);
        clear_flags();

        // R10: bus error on double-buffered entry 1
        bus_inj = 1'b1;
        bus_inj_ofs = word_at(DB_BASE + 32'd12);
        build_exp(1, 0, 2, 1'b0);
        start(1, 0, 3, 1'b0, 7'h40);
        wait_idle(400, "R10", took);
        bus_inj = 1'b0;
        compare_writes("R10 truncated");
        cfg_read('h00, r);
        check(r[22:16] == 7'b100_0000, "R10 bus-error flag only",
              {25'd0, r[22:16]}, 32'h40);
        cfg_read('h20, r);
        check(r == bus_inj_ofs, "R10 faulting offset captured", r, bus_inj_ofs);
        check(irq, "R10 bus-error interrupt", {31'd0, irq}, 32'h1);
        clear_flags();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule